// File: doc/BRIEF.md
# Pad Attribute Register Controller

This block keeps the electrical attribute word of every pad in two pad groups. One group holds the multiplexed pads and the other holds the dedicated pads. Each group has its own pad count. Software-side logic gives each pad a one-cycle write strobe and a data word. On the clock edge after the strobe, the pad's stored attribute takes that data with the unsupported bits cleared. The stored words drive the pad ring directly.

A build-time implementation selector picks which attribute bits exist. The generic build keeps bits 5:0. The FPGA-oriented build keeps only bits 1:0. Every other bit can be written with any value, but it always reads as zero. Bit 0 is the inversion control and bit 1 is the open-drain control. A selector value outside the two known builds stops elaboration with an error. An attribute width below six bits does the same.

Top module: `pad_attr_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every attribute output becomes all zeros after that edge, whatever the strobes and data are. Zero means no inversion and no open-drain.
- R2: If a pad's write strobe is high at a rising edge, that pad's attribute output shows the written data ANDed with the kept-bit mask from that edge onward.
- R3: With `IMPL` = 0 (generic build), bits 5:0 are kept and every bit above bit 5 of every attribute output is always zero.
- R4: With `IMPL` = 1 (FPGA-oriented build), bits 1:0 are kept and every bit above bit 1 of every attribute output is always zero.
- R5: A pad whose strobe is low at an edge keeps its attribute value across that edge, even when its data input changes.
- R6: A write to one pad leaves every other pad unchanged, in its own group and in the other group.
- R7: When several strobes are high in the same cycle, in either group or both, every strobed pad takes its own data at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mux_we | input | NUM_MUX | Per-pad write strobes, multiplexed group |
| mux_wdata | input | NUM_MUX*ATTR_W | Write data for the multiplexed group; pad p occupies bits [p*ATTR_W +: ATTR_W] |
| mux_attr | output | NUM_MUX*ATTR_W | Stored attributes for the multiplexed group, packed the same way as `mux_wdata` |
| ded_we | input | NUM_DED | Per-pad write strobes, dedicated group |
| ded_wdata | input | NUM_DED*ATTR_W | Write data for the dedicated group, packed the same way as `mux_wdata` |
| ded_attr | output | NUM_DED*ATTR_W | Stored attributes for the dedicated group |

## Verification
Both builds run side by side from the same stimulus, so one data word shows two different masks at the same time.

- **Reset with all strobes high and all-ones data:** shows that reset takes precedence over a write.
- **All-ones writes to the first and last pad of each group:** expose any kept bit that leaks above the mask, and any error at the edges of the packed vectors.
- **Changing data with the strobes held low:** shows the difference between holding a value and following the input.
- **Every strobe in both groups high at once:** shows that simultaneous writes do not interfere.
- **Long run of sparse random strobes with random data:** shows that each pad and each group updates independently of the others.

// File: rtl/pad_attr_pkg.sv
// Package: shared definitions for the pad attribute controller.
// Gives the codes of the implementation selector and the number of kept
// low-order attribute bits for each build. Unknown codes map to zero kept
// bits, and the top module treats that as an elaboration error.
package pad_attr_pkg;

    localparam int IMPL_GENERIC = 0;
    localparam int IMPL_FPGA    = 1;

    // Number of low-order attribute bits a build keeps; 0 marks an unknown code.
    function automatic int kept_bits(input int impl);
        case (impl)
            IMPL_GENERIC: return 6;
            IMPL_FPGA:    return 2;
            default:      return 0;
        endcase
    endfunction

endpackage

// File: rtl/pad_attr_slot.sv
// Module: one pad's attribute register.
// Takes the masked write data on an edge where the strobe is high and holds
// otherwise. Bits outside KEEP are never stored.
// Assumes a synchronous active-low reset and a strobe that is one cycle wide
// per write.
module pad_attr_slot #(
    parameter int ATTR_W = 8,
    parameter logic [ATTR_W-1:0] KEEP = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ATTR_W-1:0] wdata,
    output logic [ATTR_W-1:0] attr
);

    logic [ATTR_W-1:0] attr_q;

    // Register update: clear on reset, load masked data on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q <= '0;
        end else if (we) begin
            attr_q <= wdata & KEEP;
        end
    end

    assign attr = attr_q;

    // R1: reset clears the register, whatever the strobe is.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> attr == '0);

    // R2: a strobe loads the written data with the mask applied.
    p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> attr == ($past(wdata) & KEEP));

    // R5: no strobe means no change.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(attr));

    // R3 and R4: bits outside the kept set read as zero.
    p_unkept_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (attr & ~KEEP) == '0);

endmodule

// File: rtl/pad_attr_group.sv
// Module: the attribute registers of one pad group.
// Builds one slot per pad. Pad p uses bits [p*ATTR_W +: ATTR_W] of the
// packed data and attribute vectors, and strobe bit p.
// Assumes that KEEP has already been checked by the top module.
module pad_attr_group #(
    parameter int NUM_PADS = 4,
    parameter int ATTR_W = 8,
    parameter logic [ATTR_W-1:0] KEEP = '1,
    localparam int VEC_W = NUM_PADS * ATTR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] we,
    input  logic [VEC_W-1:0]    wdata,
    output logic [VEC_W-1:0]    attr
);

    // One register per pad.
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        pad_attr_slot #(
            .ATTR_W (ATTR_W),
            .KEEP   (KEEP)
        ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we[p]),
            .wdata (wdata[p*ATTR_W +: ATTR_W]),
            .attr  (attr[p*ATTR_W +: ATTR_W])
        );
    end

    // R6: with no strobe in the group, the whole group stays as it is.
    p_group_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we == '0 |=> $stable(attr));

endmodule

// File: rtl/pad_attr_ctrl.sv
// Module: top of the pad attribute controller.
// Derives the kept-bit mask from IMPL and builds one register group for the
// multiplexed pads and one for the dedicated pads.
// Elaboration stops with an error if IMPL is an unknown code or if ATTR_W is
// below 6.
module pad_attr_ctrl #(
    parameter int NUM_MUX = 6,
    parameter int NUM_DED = 4,
    parameter int ATTR_W = 8,
    parameter int IMPL = pad_attr_pkg::IMPL_GENERIC
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_MUX-1:0]        mux_we,
    input  logic [NUM_MUX*ATTR_W-1:0] mux_wdata,
    output logic [NUM_MUX*ATTR_W-1:0] mux_attr,
    input  logic [NUM_DED-1:0]        ded_we,
    input  logic [NUM_DED*ATTR_W-1:0] ded_wdata,
    output logic [NUM_DED*ATTR_W-1:0] ded_attr
);

    localparam int KEEP_BITS = pad_attr_pkg::kept_bits(IMPL);
    localparam logic [ATTR_W-1:0] KEEP_MASK = ATTR_W'((1 << KEEP_BITS) - 1);

    // Build-time legality: stop elaboration on an unknown build or a narrow word.
    if (KEEP_BITS == 0) begin : g_bad_impl
        $error("pad_attr_ctrl: unsupported IMPL value %0d", IMPL);
    end
    if (ATTR_W < 6) begin : g_bad_width
        $error("pad_attr_ctrl: ATTR_W must be at least 6");
    end

    // Multiplexed pad group.
    pad_attr_group #(
        .NUM_PADS (NUM_MUX),
        .ATTR_W   (ATTR_W),
        .KEEP     (KEEP_MASK)
    ) u_mux_grp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mux_we),
        .wdata (mux_wdata),
        .attr  (mux_attr)
    );

    // Dedicated pad group.
    pad_attr_group #(
        .NUM_PADS (NUM_DED),
        .ATTR_W   (ATTR_W),
        .KEEP     (KEEP_MASK)
    ) u_ded_grp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ded_we),
        .wdata (ded_wdata),
        .attr  (ded_attr)
    );

    // R6: a write to the multiplexed group only leaves the dedicated group alone.
    p_cross_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ded_we == '0 && mux_we != '0) |=> $stable(ded_attr));

endmodule

// File: tb/pad_attr_ctrl_bench.sv
// Bench: runs the generic and FPGA builds side by side against a bench model.
// Inputs change on the falling edge. Outputs are compared on the following
// falling edge, after the model has taken in the rising edge between them.
module pad_attr_ctrl_bench;

    localparam int NM = 6;
    localparam int ND = 4;
    localparam int W  = 8;
    localparam int NP = NM + ND;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NM-1:0]   mux_we = '0;
    logic [NM*W-1:0] mux_wdata = '0;
    logic [ND-1:0]   ded_we = '0;
    logic [ND*W-1:0] ded_wdata = '0;
    logic [NM*W-1:0] mux_attr_g, mux_attr_f;
    logic [ND*W-1:0] ded_attr_g, ded_attr_f;

    int total = 0;
    int bad = 0;
    logic [W-1:0] exp_g [NP];
    logic [W-1:0] exp_f [NP];

    // 50 MHz clock.
    always #10 clk = ~clk;

    pad_attr_ctrl #(.NUM_MUX(NM), .NUM_DED(ND), .ATTR_W(W), .IMPL(0)) u_pad_attr_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mux_we(mux_we), .mux_wdata(mux_wdata), .mux_attr(mux_attr_g),
        .ded_we(ded_we), .ded_wdata(ded_wdata), .ded_attr(ded_attr_g));

    pad_attr_ctrl #(.NUM_MUX(NM), .NUM_DED(ND), .ATTR_W(W), .IMPL(1)) u_pad_attr_ctrl_fpga (
        .clk(clk), .rst_n(rst_n),
        .mux_we(mux_we), .mux_wdata(mux_wdata), .mux_attr(mux_attr_f),
        .ded_we(ded_we), .ded_wdata(ded_wdata), .ded_attr(ded_attr_f));

    // Kept-bit masks taken from R3 and R4.
    function automatic logic [W-1:0] mask_gen();
        return W'(8'h3F);
    endfunction
    function automatic logic [W-1:0] mask_fpga();
        return W'(8'h03);
    endfunction

    // Pad p counts the multiplexed pads first, then the dedicated pads.
    function automatic logic pad_we(int p);
        return (p < NM) ? mux_we[p] : ded_we[p-NM];
    endfunction
    function automatic logic [W-1:0] pad_wd(int p);
        return (p < NM) ? mux_wdata[p*W +: W] : ded_wdata[(p-NM)*W +: W];
    endfunction
    function automatic logic [W-1:0] got_g(int p);
        return (p < NM) ? mux_attr_g[p*W +: W] : ded_attr_g[(p-NM)*W +: W];
    endfunction
    function automatic logic [W-1:0] got_f(int p);
        return (p < NM) ? mux_attr_f[p*W +: W] : ded_attr_f[(p-NM)*W +: W];
    endfunction

    task automatic chk(input string tag, input int p, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s pad %0d got=%h exp=%h", tag, p, got, exp);
        end
    endtask

    // Falling edge: compare every pad, then drive the inputs for the next edge.
    // The model is then updated just after the rising edge.
    logic strobed [NP];
    task automatic cycle(input string tag, input logic [NM-1:0] mwe,
                         input logic [NM*W-1:0] mwd, input logic [ND-1:0] dwe,
                         input logic [ND*W-1:0] dwd);
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            string t;
            t = (tag != "") ? tag : (strobed[p] ? "R2" : "R5 R6");
            chk({t, " generic"}, p, got_g(p), exp_g[p]);
            chk({t, " fpga"}, p, got_f(p), exp_f[p]);
            chk("R3", p, got_g(p) & ~mask_gen(), '0);
            chk("R4", p, got_f(p) & ~mask_fpga(), '0);
        end
        mux_we = mwe; mux_wdata = mwd; ded_we = dwe; ded_wdata = dwd;
        @(posedge clk);
        #1;
        for (int p = 0; p < NP; p++) begin
            strobed[p] = pad_we(p);
            if (!rst_n) begin
                exp_g[p] = '0;
                exp_f[p] = '0;
            end else if (pad_we(p)) begin
                exp_g[p] = pad_wd(p) & mask_gen();
                exp_f[p] = pad_wd(p) & mask_fpga();
            end
        end
    endtask

    // Watchdog.
    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NM-1:0] mwe;
        logic [ND-1:0] dwe;
        logic [NM*W-1:0] mwd;
        logic [ND*W-1:0] dwd;
        void'($urandom(32'd1234));
        for (int p = 0; p < NP; p++) begin
            exp_g[p] = '0;
            exp_f[p] = '0;
            strobed[p] = 1'b0;
        end
        // R1: reset while every strobe is high with all-ones data.
        @(negedge clk);
        mux_we = '1; mux_wdata = '1; ded_we = '1; ded_wdata = '1;
        repeat (3) @(posedge clk);
        #1;
        cycle("R1", '1, '1, '1, '1);
        rst_n = 1'b1;
        cycle("R1", '0, '0, '0, '0);
        // R3 and R4: all-ones writes to the first and last pad of each group.
        cycle("R1", NM'(1) | (NM'(1) << (NM-1)), '1, ND'(1) | (ND'(1) << (ND-1)), '1);
        // R5: the data changes while the strobes stay low.
        cycle("", '0, {(NM*W){1'b0}}, '0, '0);
        cycle("", '0, {NM{8'h5A}}, '0, {ND{8'hA5}});
        // R7: every strobe high at once, with a different value for each pad.
        for (int p = 0; p < NM; p++) mwd[p*W +: W] = W'(8'h11 * (p + 1));
        for (int p = 0; p < ND; p++) dwd[p*W +: W] = W'(8'hC3 ^ p);
        cycle("", '0, '0, '0, '0);
        cycle("R7", '1, mwd, '1, dwd);
        cycle("R7", '0, '0, '0, '0);
        // Random strobes (sparse) and random data, for R2, R5 and R6.
        for (int i = 0; i < 3000; i++) begin
            for (int p = 0; p < NM; p++) begin
                mwe[p] = ($urandom_range(0, 5) == 0);
                mwd[p*W +: W] = W'($urandom);
            end
            for (int p = 0; p < ND; p++) begin
                dwe[p] = ($urandom_range(0, 5) == 0);
                dwd[p*W +: W] = W'($urandom);
            end
            cycle("", mwe, mwd, dwe, dwd);
        end
        // R1: reset again, to clear the values the random writes left.
        rst_n = 1'b0;
        cycle("", '0, '0, '0, '0);
        rst_n = 1'b1;
        cycle("R1", '0, '0, '0, '0);
        cycle("R1", '0, '0, '0, '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule